// File: doc/BRIEF.md
# Prefetching Stream Register Bus Bridge

This bridge sits between one internal-bus slave port and a data-decoder core. The core offers two kinds of targets: a bank of ordinary control and status registers, and a single stream-data register that drains a sector buffer. Each bus access is decoded by its address. Accesses to the stream address go to a stream branch. Every other address goes to a register branch that drives the core's synchronous register file.

The stream branch does not wait for the bus. Whenever its holding slot is empty, it pulls the next word from the core over a valid/ready handshake. A bus read of the stream address is therefore granted in the same cycle and answered from that slot. Register reads return their data through a second holding register. As a result, a word that has already been prefetched survives any number of register accesses that arrive in between.

The bus side uses a request/grant pair. An access is accepted in a cycle where both `bus_req` and `bus_gnt` are high. Read data comes back later, marked by `bus_rvalid`.

Top module: `strm_bus_bridge`

## Requirements
- R1: While `rst` is high, `strm_ready` and `bus_rvalid` are low. In the first cycle after `rst` falls, the stream slot is empty, so `strm_ready` is high.
- R2: Outside reset, `strm_ready` is high exactly when the stream slot is empty. A core handshake (`strm_valid` and `strm_ready` high at a clock edge) fills the slot, and `strm_ready` then stays low with no bus activity until a stream read consumes the word. Each handshake takes one word.
- R3: A read (`bus_we`=0) of address `STRM_ADDR` with a full slot is granted in the same cycle. In the next cycle `bus_rvalid` is high and `bus_rdata` carries the held word. Words reach the bus in the order the core offered them.
- R4: A stream read that finds the slot empty sees `bus_gnt` low until a core word has been loaded. It is then granted and served as in R3.
- R5: In the cycle after a stream read is accepted, `strm_ready` is high, so a refill can start at once.
- R6: A read of any address other than `STRM_ADDR` pulses `reg_rd` with `reg_addr` in its acceptance cycle. The core returns `reg_rdata` one cycle later. `bus_rvalid` is low in the cycle after acceptance and high two cycles after acceptance, carrying that data. `bus_gnt` is low in the cycle after acceptance.
- R7: Register reads never disturb a prefetched stream word. The next stream read still returns the next word in core order.
- R8: A write to any address other than `STRM_ADDR` pulses `reg_wr` with `reg_addr` and `reg_wdata` in its acceptance cycle. It produces no `bus_rvalid` in the following cycle.
- R9: A write to `STRM_ADDR` is accepted and discarded. It produces no `reg_wr`, no response, and no change to the stream sequence.
- R10: No stream word is dropped or duplicated. Since reset, the count of core handshakes equals the count of accepted stream reads plus one if the slot is currently full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Access address |
| bus_wdata | input | DATA_W | Write data |
| bus_gnt | output | 1 | Access accepted this cycle when high with `bus_req` |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | DATA_W | Read data |
| reg_wr | output | 1 | Register-file write strobe |
| reg_rd | output | 1 | Register-file read strobe |
| reg_addr | output | ADDR_W | Register-file address |
| reg_wdata | output | DATA_W | Register-file write data |
| reg_rdata | input | DATA_W | Register-file read data, one cycle after `reg_rd` |
| strm_valid | input | 1 | Core stream word available |
| strm_ready | output | 1 | Bridge takes a core stream word |
| strm_data | input | DATA_W | Core stream word |

## Verification
Two activities can land in the same cycle: the prefetch handshake with the core, and a register read (or its response) on the bus. Random traffic mixes register reads and writes with stream reads while the core's `strm_valid` toggles at random. This makes refills frequently coincide with register accesses. Every stream response is compared with the next word of the core's sequence, and every register response with a bench shadow of the written values. A directed case starves the core so that a stream read must stall. Another presents a stream read in the busy cycle right after a register read.

// File: rtl/bb_pkg.sv
package bb_pkg;

    parameter int BB_AW = 8;
    parameter int BB_DW = 32;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_REG_RD,
        ACC_REG_WR,
        ACC_STRM_RD,
        ACC_STRM_WR
    } acc_kind_e;

    typedef struct packed {
        logic             vld;
        logic [BB_DW-1:0] data;
    } word_slot_t;

    function automatic acc_kind_e classify(input logic req, input logic we, input logic hit);
        if (!req)
            return ACC_IDLE;
        if (hit)
            return we ? ACC_STRM_WR : ACC_STRM_RD;
        return we ? ACC_REG_WR : ACC_REG_RD;
    endfunction

endpackage

// File: rtl/bb_decode.sv
module bb_decode
    import bb_pkg::*;
#(
    parameter int               AW        = BB_AW,
    parameter logic [AW-1:0]    STRM_ADDR = '0
) (
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    output acc_kind_e     kind
);
    logic hit;

    assign hit  = (addr == STRM_ADDR);
    assign kind = classify(req, we, hit);
endmodule

// File: rtl/bb_prefetch.sv
module bb_prefetch
    import bb_pkg::*;
#(
    parameter int DW = BB_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strm_valid,
    input  logic [DW-1:0] strm_data,
    input  logic          take,
    output logic          strm_ready,
    output word_slot_t    slot
);
    word_slot_t slot_q;

    // Fetch only into an empty slot; reset blocks any handshake in flight.
    assign strm_ready = !rst && !slot_q.vld;
    assign slot       = slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (strm_valid && strm_ready) begin
            slot_q.vld  <= 1'b1;
            slot_q.data <= strm_data;
        end else if (take) begin
            slot_q.vld <= 1'b0;
        end
    end
endmodule

// File: rtl/bb_reg_path.sv
module bb_reg_path
    import bb_pkg::*;
#(
    parameter int DW = BB_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_issue,
    input  logic [DW-1:0] reg_rdata,
    output logic          pend,
    output word_slot_t    rsp
);
    logic       pend_q;
    word_slot_t rsp_q;

    assign pend = pend_q;
    assign rsp  = rsp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            rsp_q  <= '0;
        end else begin
            pend_q    <= rd_issue;
            rsp_q.vld <= pend_q;
            if (pend_q)
                rsp_q.data <= reg_rdata;
        end
    end
endmodule

// File: rtl/strm_bus_bridge.sv
module strm_bus_bridge
    import bb_pkg::*;
#(
    parameter int                   ADDR_W    = BB_AW,
    parameter int                   DATA_W    = BB_DW,
    parameter logic [ADDR_W-1:0]    STRM_ADDR = 'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_gnt,
    output logic              bus_rvalid,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              strm_valid,
    output logic              strm_ready,
    input  logic [DATA_W-1:0] strm_data
);
    acc_kind_e  kind;
    word_slot_t pf_slot;
    word_slot_t reg_rsp;
    word_slot_t strm_rsp_q;
    logic       reg_busy;
    logic       strm_take;

    bb_decode #(.AW(ADDR_W), .STRM_ADDR(STRM_ADDR)) u_dec (
        .req  (bus_req),
        .we   (bus_we),
        .addr (bus_addr),
        .kind (kind)
    );

    bb_prefetch #(.DW(DATA_W)) u_pf (
        .clk        (clk),
        .rst        (rst),
        .strm_valid (strm_valid),
        .strm_data  (strm_data),
        .take       (strm_take),
        .strm_ready (strm_ready),
        .slot       (pf_slot)
    );

    bb_reg_path #(.DW(DATA_W)) u_rp (
        .clk       (clk),
        .rst       (rst),
        .rd_issue  (reg_rd),
        .reg_rdata (reg_rdata),
        .pend      (reg_busy),
        .rsp       (reg_rsp)
    );

    // Grant: stream reads need a full slot; nothing is taken while a register read is completing.
    always_comb begin
        unique case (kind)
            ACC_IDLE:    bus_gnt = 1'b0;
            ACC_STRM_RD: bus_gnt = pf_slot.vld && !reg_busy;
            default:     bus_gnt = !reg_busy;
        endcase
    end

    assign strm_take = (kind == ACC_STRM_RD) && bus_gnt;
    assign reg_rd    = (kind == ACC_REG_RD) && bus_gnt;
    assign reg_wr    = (kind == ACC_REG_WR) && bus_gnt;
    assign reg_addr  = bus_addr;
    assign reg_wdata = bus_wdata;

    // Stream response register, separate from the register response path.
    always_ff @(posedge clk) begin
        if (rst) begin
            strm_rsp_q <= '0;
        end else begin
            strm_rsp_q.vld <= strm_take;
            if (strm_take)
                strm_rsp_q.data <= pf_slot.data;
        end
    end

    assign bus_rvalid = strm_rsp_q.vld || reg_rsp.vld;
    assign bus_rdata  = strm_rsp_q.vld ? strm_rsp_q.data : reg_rsp.data;
endmodule

// File: rtl/bb_checker.sv
module bb_checker #(
    parameter int               AW        = 8,
    parameter logic [AW-1:0]    STRM_ADDR = 'h40
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_req,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic          bus_gnt,
    input logic          bus_rvalid,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic          strm_valid,
    input logic          strm_ready
);
    logic strm_rd_req;
    logic strm_wr_req;

    assign strm_rd_req = bus_req && !bus_we && (bus_addr == STRM_ADDR);
    assign strm_wr_req = bus_req && bus_we && (bus_addr == STRM_ADDR);

    assert_reset_ready_R1: assert property (@(posedge clk) rst |-> !strm_ready);
    assert_reset_rvalid_R1: assert property (@(posedge clk) rst |=> !bus_rvalid);

    assert_single_fetch_R2: assert property (@(posedge clk) disable iff (rst)
        (strm_valid && strm_ready) |=> !strm_ready);

    assert_strm_rsp_R3: assert property (@(posedge clk) disable iff (rst)
        (strm_rd_req && bus_gnt) |=> bus_rvalid);

    assert_stall_empty_R4: assert property (@(posedge clk) disable iff (rst)
        (strm_rd_req && strm_ready) |-> !bus_gnt);

    assert_refill_next_R5: assert property (@(posedge clk) disable iff (rst)
        (strm_rd_req && bus_gnt) |=> strm_ready);

    assert_reg_latency_R6: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> (!bus_rvalid && !bus_gnt) ##1 bus_rvalid);

    assert_write_no_rsp_R8: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !bus_rvalid);

    assert_strm_write_dropped_R9: assert property (@(posedge clk) disable iff (rst)
        strm_wr_req |-> (!reg_wr && !reg_rd));
endmodule

bind strm_bus_bridge bb_checker #(.AW(ADDR_W), .STRM_ADDR(STRM_ADDR)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_gnt    (bus_gnt),
    .bus_rvalid (bus_rvalid),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .strm_valid (strm_valid),
    .strm_ready (strm_ready)
);

// File: tb/strm_bus_bridge_bench.sv
`timescale 1ns/1ps
module strm_bus_bridge_bench;
    localparam int         AW    = 8;
    localparam int         DW    = 32;
    localparam logic [7:0] SADDR = 8'h40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_req = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_gnt, bus_rvalid;
    logic [DW-1:0] bus_rdata;
    logic          reg_wr, reg_rd;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] reg_wdata;
    logic [DW-1:0] reg_rdata = '0;
    logic          strm_valid = 1'b0;
    logic          strm_ready;
    logic [DW-1:0] strm_data;

    int            n_chk = 0;
    int            n_bad = 0;
    bit            starve = 1'b0;
    bit            done = 1'b0;
    int            src_seq = 0;
    int            hs_cnt = 0;
    int            wr_cnt = 0;
    int            exp_idx = 0;
    int            rd_cnt = 0;
    logic [DW-1:0] core_mem [16];
    logic [DW-1:0] exp_mem [16];

    always #2 clk = ~clk;

    strm_bus_bridge #(.ADDR_W(AW), .DATA_W(DW), .STRM_ADDR(SADDR)) u_strm_bus_bridge (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .strm_valid(strm_valid), .strm_ready(strm_ready),
        .strm_data(strm_data)
    );

    function automatic logic [DW-1:0] word_of(input int i);
        return 32'h5A00_0000 + i * 32'h0001_0307;
    endfunction

    assign strm_data = word_of(src_seq);

    // Core model: random stream source and synchronous register file.
    always @(posedge clk) begin
        if (strm_valid && strm_ready) begin
            src_seq    <= src_seq + 1;
            hs_cnt     <= hs_cnt + 1;
            strm_valid <= !starve && ($urandom % 4 != 0);
        end else if (!strm_valid) begin
            strm_valid <= !starve && ($urandom % 4 != 0);
        end
        if (rst) begin
            hs_cnt <= 0;
            for (int k = 0; k < 16; k++) core_mem[k] <= '0;
        end else begin
            if (reg_wr) begin
                core_mem[reg_addr[3:0]] <= reg_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (reg_rd) reg_rdata <= core_mem[reg_addr[3:0]];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic accept(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int stall = 0;
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        #1;
        while (!bus_gnt && stall < 1000) begin
            @(negedge clk); #1; stall++;
        end
        @(posedge clk);
    endtask

    task automatic strm_read();
        accept(1'b0, SADDR, '0);
        @(negedge clk); bus_req = 1'b0; #1;
        chk(bus_rvalid, "R3 stream response valid", {31'd0, bus_rvalid}, 32'd1);
        chk(bus_rdata == word_of(exp_idx), "R3/R7 stream word order", bus_rdata, word_of(exp_idx));
        chk(strm_ready, "R5 refill ready after read", {31'd0, strm_ready}, 32'd1);
        exp_idx++; rd_cnt++;
    endtask

    task automatic reg_read(input logic [3:0] a);
        accept(1'b0, {4'h0, a}, '0);
        @(negedge clk); bus_req = 1'b0; #1;
        chk(!bus_rvalid, "R6 no response one cycle after", {31'd0, bus_rvalid}, 32'd0);
        @(negedge clk); #1;
        chk(bus_rvalid && bus_rdata == exp_mem[a], "R6 register read data", bus_rdata, exp_mem[a]);
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [DW-1:0] d);
        accept(1'b1, {4'h0, a}, d);
        @(negedge clk); bus_req = 1'b0; #1;
        exp_mem[a] = d;
        chk(!bus_rvalid, "R8 write has no response", {31'd0, bus_rvalid}, 32'd0);
        chk(core_mem[a] == d, "R8 write reached register file", core_mem[a], d);
    endtask

    task automatic strm_write(input logic [DW-1:0] d);
        int w0 = wr_cnt;
        accept(1'b1, SADDR, d);
        @(negedge clk); bus_req = 1'b0; #1;
        chk(!bus_rvalid, "R9 stream write no response", {31'd0, bus_rvalid}, 32'd0);
        chk(wr_cnt == w0, "R9 stream write not routed", wr_cnt, w0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        bus_req = 1'b0; rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(!strm_ready, "R1 ready low in reset", {31'd0, strm_ready}, 32'd0);
        chk(!bus_rvalid, "R1 rvalid low in reset", {31'd0, bus_rvalid}, 32'd0);
        for (int k = 0; k < 16; k++) exp_mem[k] = '0;
        exp_idx = src_seq; rd_cnt = 0;
        @(negedge clk); rst = 1'b0; #1;
        chk(strm_ready, "R1 slot empty after reset", {31'd0, strm_ready}, 32'd1);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R2: prefetch without any bus request, then held.
        begin
            int w = 0;
            while (strm_ready && w < 50) begin @(negedge clk); #1; w++; end
        end
        chk(!strm_ready, "R2 prefetch without request", {31'd0, strm_ready}, 32'd0);
        repeat (3) @(negedge clk);
        #1;
        chk(!strm_ready, "R2 word held while idle", {31'd0, strm_ready}, 32'd0);
        chk(hs_cnt == 1, "R2 single handshake", hs_cnt, 1);

        // R7: register traffic between prefetch and stream read.
        reg_write(4'd3, 32'hDEAD_0003);
        reg_read(4'd3);
        reg_read(4'd0);
        strm_read();

        // R9: write to the stream address leaves the sequence intact.
        strm_write(32'hFFFF_FFFF);
        strm_read();

        // R6: stream request in the busy cycle after a register read.
        begin
            int w = 0;
            while (strm_ready && w < 50) begin @(negedge clk); #1; w++; end
        end
        accept(1'b0, 8'h05, '0);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = SADDR; #1;
        chk(!bus_gnt, "R6 grant low after register read", {31'd0, bus_gnt}, 32'd0);
        @(negedge clk); #1;
        chk(bus_rvalid && bus_rdata == exp_mem[5], "R6 register data", bus_rdata, exp_mem[5]);
        chk(bus_gnt, "R6 grant returns", {31'd0, bus_gnt}, 32'd1);
        @(posedge clk);
        @(negedge clk); bus_req = 1'b0; #1;
        chk(bus_rvalid && bus_rdata == word_of(exp_idx), "R3 stream after busy", bus_rdata, word_of(exp_idx));
        exp_idx++; rd_cnt++;

        // R4: starve the core, drain, then a stream read must stall.
        starve = 1'b1;
        @(negedge clk); #1;
        while (!(strm_ready && !strm_valid)) strm_read();
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = SADDR;
        for (int k = 0; k < 5; k++) begin
            #1;
            chk(!bus_gnt, "R4 stall on empty slot", {31'd0, bus_gnt}, 32'd0);
            @(negedge clk);
        end
        bus_req = 1'b0;
        starve = 1'b0;
        strm_read();

        // Random mix, one reset in the middle.
        for (int i = 0; i < 1500; i++) begin
            int r = $urandom % 100;
            if (i == 700) do_reset();
            if (r < 40)      strm_read();
            else if (r < 70) reg_read(4'($urandom % 16));
            else if (r < 95) reg_write(4'($urandom % 16), $urandom);
            else             strm_write($urandom);
        end

        // R10: no drop or duplicate.
        repeat (10) @(negedge clk);
        #1;
        chk(hs_cnt - rd_cnt == (strm_ready ? 0 : 1), "R10 handshakes vs reads",
            hs_cnt - rd_cnt, strm_ready ? 0 : 1);
        summary();
    end
endmodule